// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer for a Synchronous RAM

This block puts a small synchronous RAM into a low-power sleep state and brings it back out in a controlled way. The sleep request comes from a pin with no timing relationship to the clock, so it first passes through a chain of flip-flops. The synchronised level then drives a state machine with four states: awake, entering, asleep and recovering. Each transition window lasts a fixed number of clock cycles.

While the machine is entering or recovering, reads are still served and writes are refused. A refused write raises a one-cycle violation flag. While asleep, every access is ignored and the read data bus is released. The released bus is modelled as an output-enable that is low, with the data forced to zero. A ready flag tells the access controller when normal traffic, including writes, may go on. The storage array keeps its contents through the whole sequence.

An access controller drives `acc_rd`, `acc_wr`, the address and the write data. It uses `acc_gate` and `ready` to decide what it may issue.

Top module: `sram_sleep_seq`

## Requirements
- R1: After reset, ready=1, acc_gate=1, bus_off=0, wr_viol=0, rd_valid=0 and rd_data=0.
- R2: With the default two-stage synchroniser, ready falls at the second rising edge after the first edge that samples sleep_raw high. Until then, ready stays 1 and accesses behave as when awake.
- R3: ENTRY_CYC edges after ready falls, the block is asleep: bus_off=1, acc_gate=0 and ready=0.
- R4: While asleep, a read gives rd_valid=0 and rd_data=0, and a write leaves the stored data unchanged and does not raise wr_viol.
- R5: When sleep_raw returns low, bus_off falls at the second edge after the first edge that samples it low, with ready=0 and acc_gate=1. ready rises EXIT_CYC edges later.
- R6: During the entry and recovery windows a read is served: rd_valid=1 one cycle later with the stored data, provided the block has not gone to sleep by then.
- R7: A write issued during the entry or recovery window is not performed, and wr_viol is 1 for exactly the following cycle.
- R8: Sleep has priority: if the synchronised request is high again while recovering, the block returns to entry without ever raising ready, and it is asleep ENTRY_CYC edges after that.
- R9: Data written before sleep reads back unchanged after waking.
- R10: While awake, a write stores acc_wdata at acc_addr, and a read returns the stored word with rd_valid=1 one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_raw | input | 1 | Asynchronous sleep request, high requests sleep |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_addr | input | AW | Word address |
| acc_wdata | input | DW | Write data |
| acc_gate | output | 1 | Accesses accepted (low only while asleep) |
| bus_off | output | 1 | Read data bus released (asleep) |
| ready | output | 1 | Fully awake, writes allowed |
| wr_viol | output | 1 | One-cycle pulse after a write refused in a transition window |
| rd_valid | output | 1 | Read data driven this cycle |
| rd_data | output | DW | Read data, zero when not driven |

## Verification
Full sweeps of every address are written and read while awake, then repeated while asleep and after waking. These sweeps separate data that is actually held from writes that were wrongly let through during sleep. Single accesses placed on each cycle of the entry and recovery windows separate a read that is served from a write that is refused and flagged. The flag is checked to last exactly one cycle. Edge counts from each change of the sleep pin pin down the synchroniser and window latencies. A one-cycle low glitch during sleep shows that a new request overrides recovery without a ready pulse.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_EXIT   = 2'd3
    } slp_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sram_sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_s,
    input  logic wr_req,
    output logic rd_ok,
    output logic wr_ok,
    output logic bus_off,
    output logic ready,
    output logic wr_viol
);
    localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        slp_state_e      st;
        logic [CW-1:0]   cnt;
        logic            viol;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.viol = 1'b0;
        unique case (r_q.st)
            ST_AWAKE: begin
                if (sleep_s) begin
                    r_d.st  = ST_ENTER;
                    r_d.cnt = '0;
                end
            end
            ST_ENTER: begin
                r_d.viol = wr_req;
                if (r_q.cnt == CW'(ENTRY_CYC - 1)) begin
                    r_d.st  = ST_ASLEEP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (!sleep_s) begin
                    r_d.st  = ST_EXIT;
                    r_d.cnt = '0;
                end
            end
            ST_EXIT: begin
                r_d.viol = wr_req;
                if (sleep_s) begin
                    r_d.st  = ST_ENTER;
                    r_d.cnt = '0;
                end else if (r_q.cnt == CW'(EXIT_CYC - 1)) begin
                    r_d.st  = ST_AWAKE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_AWAKE;
            r_q.cnt  <= '0;
            r_q.viol <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ok   = (r_q.st != ST_ASLEEP);
    assign wr_ok   = (r_q.st == ST_AWAKE);
    assign bus_off = (r_q.st == ST_ASLEEP);
    assign ready   = (r_q.st == ST_AWAKE);
    assign wr_viol = r_q.viol;
endmodule

// File: rtl/sleep_store.sv
module sleep_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          bus_off,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } rd_regs_t;

    logic [DW-1:0] mem [DEPTH];
    rd_regs_t      p_d, p_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_comb begin
        p_d     = p_q;
        p_d.vld = rd_en;
        if (rd_en) p_d.data = mem[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.data <= '0;
            p_q.vld  <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rd_valid = p_q.vld & ~bus_off;
    assign rd_data  = rd_valid ? p_q.data : '0;
endmodule

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq #(
    parameter int AW          = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_raw,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic          acc_gate,
    output logic          bus_off,
    output logic          ready,
    output logic          wr_viol,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic sleep_s;
    logic rd_ok, wr_ok;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sleep_raw),
        .dout  (sleep_s)
    );

    sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_s (sleep_s),
        .wr_req  (acc_wr),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .bus_off (bus_off),
        .ready   (ready),
        .wr_viol (wr_viol)
    );

    sleep_store #(.AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr & wr_ok),
        .rd_en    (acc_rd & rd_ok),
        .addr     (acc_addr),
        .wdata    (acc_wdata),
        .bus_off  (bus_off),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign acc_gate = rd_ok;
endmodule

// File: rtl/sram_sleep_seq_chk.sv
module sram_sleep_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_raw,
    input logic acc_rd,
    input logic acc_wr,
    input logic acc_gate,
    input logic bus_off,
    input logic ready,
    input logic wr_viol,
    input logic rd_valid
);
    a_r7_viol_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_viol |-> ($past(acc_wr) && !$past(ready) && !$past(bus_off)));

    a_r4_no_read_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(acc_rd) && !$past(bus_off) && !bus_off));

    a_r2_ready_fall_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(sleep_raw, 2));

    a_r5_ready_rise_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !$past(sleep_raw, 2));

    a_r3_sleep_via_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> ($past(acc_gate) && !$past(ready) && !acc_gate));

    a_r5_wake_via_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off) |-> (!ready && acc_gate));
endmodule

bind sram_sleep_seq sram_sleep_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_raw (sleep_raw),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_gate  (acc_gate),
    .bus_off   (bus_off),
    .ready     (ready),
    .wr_viol   (wr_viol),
    .rd_valid  (rd_valid)
);

// File: tb/tb_sram_sleep_seq.sv
`timescale 1ns/1ps
module tb_sram_sleep_seq;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_raw;
    logic          acc_rd, acc_wr;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic          acc_gate, bus_off, ready, wr_viol, rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #4 clk = ~clk;

    sram_sleep_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_raw(sleep_raw),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_gate(acc_gate), .bus_off(bus_off),
        .ready(ready), .wr_viol(wr_viol), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input int v);
        acc_addr = AW'(a); acc_wdata = DW'(v); acc_wr = 1'b1;
        tick();
        acc_wr = 1'b0;
    endtask

    task automatic do_read(input int a);
        acc_addr = AW'(a); acc_rd = 1'b1;
        tick();
        acc_rd = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a);
            chk({req, " valid"}, rd_valid, 1);
            chk({req, " data"}, rd_data, ref_mem[a]);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sleep_raw = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
        acc_addr = '0; acc_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 ready", ready, 1);
        chk("R1 acc_gate", acc_gate, 1);
        chk("R1 bus_off", bus_off, 0);
        chk("R1 wr_viol", wr_viol, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rd_data", rd_data, 0);

        // R10 awake write and read sweep
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = DW'((a * 37 + 5) & 8'hFF);
            do_write(a, ref_mem[a]);
        end
        read_all("R10");

        // R2 entry latency
        sleep_raw = 1'b1;
        tick(); chk("R2 ready e0", ready, 1);
        tick(); chk("R2 ready e1", ready, 1);
        tick(); chk("R2 ready e2", ready, 0);
        chk("R2 gate in entry", acc_gate, 1);
        chk("R2 bus_off in entry", bus_off, 0);
        // R6 read in entry window
        do_read(2);
        chk("R6 entry rd_valid", rd_valid, 1);
        chk("R6 entry rd_data", rd_data, ref_mem[2]);
        // R7 write in entry window, R3 asleep
        do_write(2, ~ref_mem[2]);
        chk("R7 entry wr_viol", wr_viol, 1);
        chk("R3 bus_off", bus_off, 1);
        chk("R3 acc_gate", acc_gate, 0);
        chk("R3 ready", ready, 0);
        tick();
        chk("R7 viol one cycle", wr_viol, 0);

        // R4 accesses ignored asleep
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, ~ref_mem[a]);
            chk("R4 no viol asleep", wr_viol, 0);
            do_read(a);
            chk("R4 rd_valid asleep", rd_valid, 0);
            chk("R4 rd_data asleep", rd_data, 0);
        end

        // R5 exit latency
        sleep_raw = 1'b0;
        tick(); chk("R5 bus_off e0", bus_off, 1);
        tick(); chk("R5 bus_off e1", bus_off, 1);
        tick(); chk("R5 bus_off e2", bus_off, 0);
        chk("R5 ready in recovery", ready, 0);
        chk("R5 gate in recovery", acc_gate, 1);
        do_write(7, ~ref_mem[7]);
        chk("R7 recovery wr_viol", wr_viol, 1);
        chk("R5 ready mid recovery", ready, 0);
        do_read(5);
        chk("R5 ready after recovery", ready, 1);
        chk("R6 recovery rd_valid", rd_valid, 1);
        chk("R6 recovery rd_data", rd_data, ref_mem[5]);
        chk("R7 viol cleared", wr_viol, 0);

        // R9 retention, also covers R4 and R7 writes not stored
        read_all("R9");

        // R8 sleep priority over recovery
        sleep_raw = 1'b1;
        repeat (6) tick();
        chk("R8 asleep first", bus_off, 1);
        sleep_raw = 1'b0;
        tick();
        sleep_raw = 1'b1;
        tick(); chk("R8 still asleep", bus_off, 1);
        tick(); chk("R8 recovery starts", bus_off, 0);
        chk("R8 ready low recovering", ready, 0);
        tick(); chk("R8 back to entry ready", ready, 0);
        chk("R8 back to entry bus", bus_off, 0);
        tick(); chk("R8 entry second ready", ready, 0);
        tick(); chk("R8 asleep again", bus_off, 1);
        sleep_raw = 1'b0;
        repeat (6) tick();
        chk("R5 awake again", ready, 1);
        read_all("R9 second");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule